// File: doc/BRIEF.md
# Paired Set/Clear Status Register

This block holds the run-control and signalling flags of a small coprocessor. A host changes them through one 32-bit write port. Every flag owns two bits in the written word: one asks for the flag to be cleared and one asks for it to be set. When only one of the two bits is high, the flag takes that value. When both are high, or neither is, the flag keeps its value. This lets software change any subset of flags in one write without first reading the status, and it makes a conflicting request harmless.

The flags are halt, broke, single-step, interrupt-on-break and a set of general signal bits. There is also an interrupt line that leaves the block on its own output. Broke can only be cleared by a write. It is set by a break event from the core, and that event sets halt in the same cycle. After each write the block raises a one-cycle check indication when the result leaves the processor halted or the interrupt line high. This tells the sequencer that it must stop issuing instructions or service the interrupt.

Top module: `paired_status_reg`

## Requirements
- R1: After a synchronous reset, status bit 0 (halt) is 1, all other status bits are 0, and `irq_o` and `check_o` are 0.
- R2: The readable status word has halt at bit 0, broke at bit 1, single-step at bit 2, interrupt-on-break at bit 3, and signal k at bit 4+k. Bits above the last signal bit read 0.
- R3: In the written word, flag n uses bit 2n as its clear request and bit 2n+1 as its set request. The flag order is n=0 halt, 1 broke, 2 interrupt line, 3 single-step, 4 interrupt-on-break, 5+k signal k. A write with only the set request high sets the flag, and a write with only the clear request high clears it.
- R4: A write with both requests of a flag high leaves that flag unchanged.
- R5: Write bit 2 clears broke. Write bit 3 has no effect, so no write can set broke.
- R6: `irq_o` follows its own pair (bit 4 clear, bit 5 set) under the same rules as R3 and R4.
- R7: A break event (`brk_i` high at a clock edge) makes status bits 0 and 1 read 1 after that edge.
- R8: When a write and a break event arrive at the same edge, halt and broke end up set, and the write still applies to every other flag.
- R9: After the edge that takes a write, `check_o` is 1 exactly when the resulting `irq_o` is high or halt is set. After an edge with no write, `check_o` is 0.
- R10: With no write and no break event, the status word and `irq_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | DATA_W | Written word of paired clear/set requests |
| brk_i | input | 1 | Break event from the core |
| status_o | output | DATA_W | Current status word |
| irq_o | output | 1 | Outgoing interrupt line |
| check_o | output | 1 | One-cycle indication that the core must stop or service an interrupt |

## Verification
Every flag is a single register that drives the ports directly, so a wrong set/clear resolution or a broken break path shows up on `status_o` or `irq_o` right after the faulty edge. A wrong check computation shows on `check_o` in the same cycle. The bench follows every random write or break event with a full comparison of all three outputs. Any corrupted flag is therefore reported at the first edge where it differs, and it cannot hide behind a later write. Directed cases add conflicting request pairs, attempts to set broke, and a write that collides with a break.

// File: rtl/pscr_pkg.sv
package pscr_pkg;
  // Position of each flag in the write word (pair index) and in the flag vector
  typedef enum int unsigned {
    FLG_HALT  = 0,
    FLG_BROKE = 1,
    FLG_IRQ   = 2,
    FLG_SSTEP = 3,
    FLG_IOB   = 4,
    FLG_SIG0  = 5
  } flag_idx_e;

  localparam int unsigned FIXED_FLAGS = 5;

  function automatic logic resolve_pair(input logic cur, input logic clr, input logic set);
    if (clr && !set)      return 1'b0;
    else if (set && !clr) return 1'b1;
    else                  return cur;
  endfunction
endpackage

// File: rtl/scr_wdecode.sv
module scr_wdecode #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NFLAG  = 13
) (
  input  logic [DATA_W-1:0] wdata,
  output logic [NFLAG-1:0]  clr_req,
  output logic [NFLAG-1:0]  set_req
);
  import pscr_pkg::*;

  localparam int unsigned USED_W = 2 * NFLAG;

  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign clr_req[i] = wdata[2*i];
    if (i == FLG_BROKE) begin : g_clr_only
      assign set_req[i] = 1'b0;
    end else begin : g_both
      assign set_req[i] = wdata[2*i+1];
    end
  end

  logic unused_bits;
  if (USED_W < DATA_W) begin : g_spare
    assign unused_bits = ^{wdata[DATA_W-1:USED_W], wdata[2*FLG_BROKE+1]};
  end else begin : g_nospare
    assign unused_bits = wdata[2*FLG_BROKE+1];
  end
endmodule

// File: rtl/scr_flag_cell.sv
module scr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic clr_req,
  input  logic set_req,
  input  logic force_set,
  output logic flag_d,
  output logic flag_q
);
  import pscr_pkg::*;

  always_comb begin
    flag_d = flag_q;
    if (wr_en)     flag_d = resolve_pair(flag_q, clr_req, set_req);
    if (force_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= RST_VAL;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/paired_status_reg.sv
module paired_status_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SIG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              brk_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o,
  output logic              check_o
);
  import pscr_pkg::*;

  localparam int unsigned NFLAG  = FIXED_FLAGS + NUM_SIG;
  localparam int unsigned STAT_W = 4 + NUM_SIG;

  logic [NFLAG-1:0] clr_req, set_req, force_set, flag_d, flag_q;
  logic             check_q;

  scr_wdecode #(.DATA_W(DATA_W), .NFLAG(NFLAG)) u_dec (
    .wdata   (wdata_i),
    .clr_req (clr_req),
    .set_req (set_req)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == FLG_HALT || i == FLG_BROKE) begin : g_brk
      assign force_set[i] = brk_i;
    end else begin : g_nobrk
      assign force_set[i] = 1'b0;
    end
    scr_flag_cell #(.RST_VAL(i == FLG_HALT)) u_cell (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en_i),
      .clr_req   (clr_req[i]),
      .set_req   (set_req[i]),
      .force_set (force_set[i]),
      .flag_d    (flag_d[i]),
      .flag_q    (flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) check_q <= 1'b0;
    else     check_q <= wr_en_i & (flag_d[FLG_IRQ] | flag_d[FLG_HALT]);
  end

  logic [STAT_W-1:0] stat_pack;
  assign stat_pack = {flag_q[NFLAG-1:FLG_SIG0], flag_q[FLG_IOB], flag_q[FLG_SSTEP],
                      flag_q[FLG_BROKE], flag_q[FLG_HALT]};

  assign status_o = DATA_W'(stat_pack);
  assign irq_o    = flag_q[FLG_IRQ];
  assign check_o  = check_q;
endmodule

// File: rtl/paired_status_reg_chk.sv
module paired_status_reg_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SIG = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              brk_i,
  input logic [DATA_W-1:0] status_o,
  input logic              irq_o,
  input logic              check_o
);
  // R7
  break_sets_halt_broke_chk: assert property (@(posedge clk) disable iff (rst)
    brk_i |=> (status_o[0] && status_o[1]));

  // R5
  broke_only_from_break_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[1]) |-> $past(brk_i));

  // R9
  check_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> !check_o);

  // R9
  check_value_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (check_o == (irq_o || status_o[0])));

  // R4
  halt_conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !brk_i && wdata_i[0] && wdata_i[1]) |=> $stable(status_o[0]));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(irq_o));
endmodule

bind paired_status_reg paired_status_reg_chk #(.DATA_W(DATA_W), .NUM_SIG(NUM_SIG)) u_chk (.*);

// File: tb/paired_status_reg_bench.sv
module paired_status_reg_bench;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_SIG = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              wr_en_i;
  logic [DATA_W-1:0] wdata_i;
  logic              brk_i;
  logic [DATA_W-1:0] status_o;
  logic              irq_o;
  logic              check_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  paired_status_reg #(.DATA_W(DATA_W), .NUM_SIG(NUM_SIG)) u_paired_status_reg (.*);

  // reference state
  logic       m_halt, m_broke, m_irq, m_ss, m_iob, m_chk;
  logic [7:0] m_sig;

  function automatic logic pair_res(input logic cur, input logic c, input logic s);
    if (c && !s) return 1'b0;
    if (s && !c) return 1'b1;
    return cur;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic we, input logic [31:0] d, input logic b);
    if (we) begin
      m_halt = pair_res(m_halt, d[0], d[1]);
      if (d[2]) m_broke = 1'b0;
      m_irq  = pair_res(m_irq, d[4], d[5]);
      m_ss   = pair_res(m_ss, d[6], d[7]);
      m_iob  = pair_res(m_iob, d[8], d[9]);
      for (int k = 0; k < 8; k++) m_sig[k] = pair_res(m_sig[k], d[10+2*k], d[11+2*k]);
    end
    if (b) begin
      m_halt  = 1'b1;
      m_broke = 1'b1;
    end
    m_chk = we & (m_irq | m_halt);
  endtask

  function automatic logic [31:0] exp_status();
    return {20'd0, m_sig, m_iob, m_ss, m_broke, m_halt};
  endfunction

  // One edge of stimulus, then compare all outputs against the reference
  task automatic op(input logic we, input logic [31:0] d, input logic b, input string tag);
    @(negedge clk);
    wr_en_i = we; wdata_i = d; brk_i = b;
    model_step(we, d, b);
    @(posedge clk);
    #1;
    chk({tag, " status"}, status_o, exp_status());
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    chk({tag, " check"}, {31'd0, check_o}, {31'd0, m_chk});
    @(negedge clk);
    wr_en_i = 1'b0; brk_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en_i = 1'b0; wdata_i = '0; brk_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_halt = 1'b1; m_broke = 1'b0; m_irq = 1'b0; m_ss = 1'b0; m_iob = 1'b0;
    m_sig = 8'd0; m_chk = 1'b0;
    #1;
    // R1 reset state
    chk("R1 status", status_o, 32'h1);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 check", {31'd0, check_o}, 32'd0);

    // R3 clear halt alone; R9 check low with halt and irq clear
    op(1'b1, 32'h0000_0001, 1'b0, "R3 R9 halt clear");
    // R2 R3 set signal 3 (write bit 17) -> status bit 7
    op(1'b1, 32'h0002_0000, 1'b0, "R2 R3 sig3 set");
    // R3 set single-step and interrupt-on-break
    op(1'b1, 32'h0000_0280, 1'b0, "R2 R3 sstep iob set");
    // R4 both halt bits while halt clear
    op(1'b1, 32'h0000_0003, 1'b0, "R4 halt hold 0");
    op(1'b1, 32'h0000_0002, 1'b0, "R3 halt set");
    op(1'b1, 32'h0000_0003, 1'b0, "R4 halt hold 1");
    // R4 conflicting signal 3 pair
    op(1'b1, 32'h0003_0000, 1'b0, "R4 sig3 hold");
    op(1'b1, 32'h0000_0001, 1'b0, "R3 halt clear again");
    // R7 break event
    op(1'b0, 32'h0, 1'b1, "R7 break");
    // R5 bit 3 has no effect; bit 2 clears; bit 3 cannot set
    op(1'b1, 32'h0000_0008, 1'b0, "R5 set bit ignored");
    op(1'b1, 32'h0000_0005, 1'b0, "R5 broke clear");
    op(1'b1, 32'h0000_0008, 1'b0, "R5 cannot set broke");
    // R6 R9 interrupt line
    op(1'b1, 32'h0000_0020, 1'b0, "R6 R9 irq set");
    op(1'b1, 32'h0000_0030, 1'b0, "R6 irq hold");
    op(1'b1, 32'h0000_0010, 1'b0, "R6 irq clear");
    // R8 write clears halt/broke and sets signal 0 while break arrives
    op(1'b1, 32'h0000_0805, 1'b1, "R8 collision");
    // R10 idle hold
    op(1'b0, 32'hFFFF_FFFF, 1'b0, "R10 idle");

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic        we;
      logic        b;
      logic [31:0] d;
      we = ($urandom % 4) != 0;
      b  = ($urandom % 8) == 0;
      d  = $urandom;
      op(we, d, b, "R3 R6 R9 R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule